// File: doc/BRIEF.md
# Buffer-to-Host Word Transfer Engine

This engine moves 16-bit words out of a 16 KB byte-wide sector buffer to a host read port. Software loads a byte count and a starting data address, then issues a start command. The command carries a 3-bit destination selector. Only the two host-read selectors (2 and 3) make data available to the host port. Any other selector still marks the engine busy, but no words become available here.

Each host read that finds data available returns one big-endian word from the buffer. The read then advances the data address by 2 and lowers the byte count by 2. When the count, taken as a signed value, reaches zero or goes below it, the transfer is closed. Closing reloads the count, restores the active-low status flags, marks a transfer-end event as pending, sets an end flag and drops the ready flag. If the end interrupt is enabled and the external level enable is high, the engine also issues a one-cycle interrupt pulse.

The buffer sits outside the engine. The engine drives a word index and receives the two bytes at that index, with the even byte in the upper half. Control settings, count and address arrive on direct load strobes, and their decoding belongs to the surrounding logic.

Top module: `host_xfer_engine`

## Requirements
- R1: After reset, `stat_q` is 0xFF, `ctl_q`, `cnt_q` and `addr_q` are 0, `end_flag`, `ready_flag`, `done` and `irq` are 0, and `host_word` is 0xFFFF.
- R2: A `trig` pulse is accepted only when `ctl_q` bit 1 (output enable) is 1. While that bit is 0, a pulse leaves `stat_q`, `cnt_q`, `end_flag` and `ready_flag` unchanged. An accepted pulse drives `stat_q` bit 3 (busy, active low) to 0, clears `cnt_q` bits 15:12, and clears `end_flag` and `ready_flag`, all on the next clock edge.
- R3: An accepted pulse with `dest_mode` equal to 2 or 3 also drives `stat_q` bit 1 (data available, active low) to 0 and sets `ready_flag`. With any other `dest_mode`, bit 1 stays 1 and `ready_flag` stays 0.
- R4: A `host_rd` pulse while `stat_q` bit 1 is 0 loads `host_word` on the next edge. The upper byte of the word is byte a of the buffer and the lower byte is byte a+1, where a is `addr_q[13:0]` with bit 0 forced to 0. The index therefore wraps modulo 16 KB. `buf_raddr` carries `addr_q[13:1]`, and `buf_rdata` holds {byte 2i, byte 2i+1}. On the same edge, `addr_q` rises by 2 and `cnt_q` falls by 2.
- R5: When `cnt_q` minus 2, read as signed 16-bit, is at most 0 on such a read, that read closes the transfer. On the same edge `cnt_q` becomes 0xF000, `stat_q` bits 3 and 1 become 1, `stat_q` bit 6 (end pending, active low) becomes 0, `ready_flag` becomes 0 and `end_flag` becomes 1. `done` is 1 for exactly that one cycle.
- R6: `irq` pulses together with `done` only when `ctl_q` bit 6 and `lvl_en` are both 1. In every other case `irq` stays 0.
- R7: A `host_rd` pulse while `stat_q` bit 1 is 1 sets `host_word` to 0xFFFF and leaves `cnt_q`, `addr_q`, `stat_q` and both flags unchanged.
- R8: A `ctl_we` write whose data bit 1 is 0 forces `stat_q` bits 3 and 1 to 1 on the next edge, which aborts a running transfer. Any later `host_rd` then returns 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe for the interface control byte |
| ctl_data | input | 8 | Control byte: bit 1 output enable, bit 6 end-interrupt enable |
| cnt_we | input | 1 | Load strobe for the byte counter |
| cnt_data | input | 16 | Byte counter load value |
| addr_we | input | 1 | Load strobe for the data address |
| addr_data | input | 16 | Data address load value |
| trig | input | 1 | Start command pulse |
| dest_mode | input | 3 | Destination selector; 2 and 3 are host read |
| lvl_en | input | 1 | External interrupt level enable |
| host_rd | input | 1 | Host word read pulse |
| buf_rdata | input | 16 | Buffer word {even byte, odd byte} at buf_raddr |
| buf_raddr | output | 13 | Buffer word index |
| host_word | output | 16 | Last word returned to the host |
| ctl_q | output | 8 | Interface control byte |
| stat_q | output | 8 | Status byte; bits 6, 3 and 1 are active low |
| cnt_q | output | 16 | Byte counter |
| addr_q | output | 16 | Data address |
| end_flag | output | 1 | Transfer-end flag |
| ready_flag | output | 1 | Host data ready flag |
| done | output | 1 | One-cycle end-of-transfer pulse |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench targets the end test on the signed count:
- Counts of 1 and 2 must close after a single word. A design that compared unsigned values, or tested before subtracting, would emit an extra word and leave busy asserted.
- Counts with bits 15:12 set must have those bits cleared at the start. A design that kept them would see a negative count and close the transfer at once.

It also probes the buffer index:
- An odd start address must read the even byte first. A design that forgot to clear bit 0 would return byte-swapped data.
- A start at 0x3FFE must continue at buffer word 0. A design that failed to wrap would index past the buffer.

Finally, it checks reads while no data is available, starts while output is disabled, a non-host selector, and an abort in the middle of a transfer. Any of these touching the counters or flags would show up at the ports.

// File: rtl/host_xfer_pkg.sv
package host_xfer_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BUF_AW = 14;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned IDX_W  = BUF_AW - 1;
  localparam logic [CNT_W-1:0] CNT_RELOAD = {4'hF, {(CNT_W-4){1'b0}}};

  localparam int unsigned ST_PEND  = 6;
  localparam int unsigned ST_BUSY  = 3;
  localparam int unsigned ST_AVAIL = 1;
  localparam int unsigned CT_OUTEN = 1;
  localparam int unsigned CT_ENDIE = 6;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - CNT_W'(2);
  endfunction

  function automatic logic cnt_exhausted(input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] n;
    n = cnt_step(c);
    return n[CNT_W-1] || (n == '0);
  endfunction

  function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a);
    return a[BUF_AW-1:1];
  endfunction

  function automatic logic is_host_dest(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd3);
  endfunction
endpackage

// File: rtl/host_xfer_counters.sv
module host_xfer_counters
  import host_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_data,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_data,
  input  logic              trig_ok,
  input  logic              rd_fire,
  input  logic              last_word,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_data;
    end else if (last_word) begin
      cnt_q <= CNT_RELOAD;
    end else if (rd_fire) begin
      cnt_q <= cnt_step(cnt_q);
    end else if (trig_ok) begin
      cnt_q <= {4'h0, cnt_q[CNT_W-5:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_we) begin
      addr_q <= addr_data;
    end else if (rd_fire) begin
      addr_q <= addr_q + ADDR_W'(2);
    end
  end
endmodule

// File: rtl/host_xfer_status.sv
module host_xfer_status
  import host_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_data,
  input  logic       trig_ok,
  input  logic       host_dest,
  input  logic       rd_fire,
  input  logic       last_word,
  input  logic       lvl_en,
  output logic [7:0] ctl_q,
  output logic [7:0] stat_q,
  output logic       end_flag,
  output logic       ready_flag,
  output logic       done,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q     <= 8'hFF;
      end_flag   <= 1'b0;
      ready_flag <= 1'b0;
      done       <= 1'b0;
      irq        <= 1'b0;
    end else begin
      done <= 1'b0;
      irq  <= 1'b0;
      if (trig_ok) begin
        stat_q[ST_BUSY] <= 1'b0;
        end_flag        <= 1'b0;
        ready_flag      <= host_dest;
        if (host_dest) stat_q[ST_AVAIL] <= 1'b0;
      end
      if (rd_fire && last_word) begin
        stat_q[ST_BUSY]  <= 1'b1;
        stat_q[ST_AVAIL] <= 1'b1;
        stat_q[ST_PEND]  <= 1'b0;
        ready_flag       <= 1'b0;
        end_flag         <= 1'b1;
        done             <= 1'b1;
        irq              <= ctl_q[CT_ENDIE] && lvl_en;
      end
      if (ctl_we && !ctl_data[CT_OUTEN]) begin
        stat_q[ST_BUSY]  <= 1'b1;
        stat_q[ST_AVAIL] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/host_xfer_engine.sv
module host_xfer_engine
  import host_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_data,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_data,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_data,
  input  logic              trig,
  input  logic [2:0]        dest_mode,
  input  logic              lvl_en,
  input  logic              host_rd,
  input  logic [WORD_W-1:0] buf_rdata,
  output logic [IDX_W-1:0]  buf_raddr,
  output logic [WORD_W-1:0] host_word,
  output logic [7:0]        ctl_q,
  output logic [7:0]        stat_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              end_flag,
  output logic              ready_flag,
  output logic              done,
  output logic              irq
);
  logic trig_ok;
  logic rd_fire;
  logic last_word;
  logic host_dest;

  assign trig_ok   = trig && ctl_q[CT_OUTEN];
  assign rd_fire   = host_rd && !stat_q[ST_AVAIL];
  assign last_word = rd_fire && cnt_exhausted(cnt_q);
  assign host_dest = is_host_dest(dest_mode);
  assign buf_raddr = word_index(addr_q);

  host_xfer_counters u_cnt (
    .clk, .rst_n, .cnt_we, .cnt_data, .addr_we, .addr_data,
    .trig_ok, .rd_fire, .last_word, .cnt_q, .addr_q
  );

  host_xfer_status u_stat (
    .clk, .rst_n, .ctl_we, .ctl_data, .trig_ok, .host_dest,
    .rd_fire, .last_word, .lvl_en, .ctl_q, .stat_q,
    .end_flag, .ready_flag, .done, .irq
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_word <= '1;
    end else if (host_rd) begin
      host_word <= rd_fire ? buf_rdata : '1;
    end
  end
endmodule

// File: rtl/host_xfer_checker.sv
module host_xfer_checker
  import host_xfer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic [7:0]        ctl_data,
  input logic              cnt_we,
  input logic              addr_we,
  input logic              host_rd,
  input logic              trig_ok,
  input logic              rd_fire,
  input logic [7:0]        stat_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [WORD_W-1:0] host_word,
  input logic              end_flag,
  input logic              ready_flag,
  input logic              done,
  input logic              irq
);
  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ok && !ctl_we && !host_rd) |=> (!stat_q[ST_BUSY] && !end_flag));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !addr_we) |=> (addr_q == $past(addr_q) + ADDR_W'(2)));

  p_end_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stat_q[ST_BUSY] && stat_q[ST_AVAIL] && !stat_q[ST_PEND] &&
              end_flag && !ready_flag && cnt_q == CNT_RELOAD));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_irq_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  p_idle_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && stat_q[ST_AVAIL] && !cnt_we && !addr_we && !ctl_we && !trig_ok)
      |=> (host_word == '1 && $stable(cnt_q) && $stable(addr_q)));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_data[CT_OUTEN]) |=> (stat_q[ST_BUSY] && stat_q[ST_AVAIL]));
endmodule

bind host_xfer_engine host_xfer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
  .cnt_we(cnt_we), .addr_we(addr_we), .host_rd(host_rd),
  .trig_ok(trig_ok), .rd_fire(rd_fire), .stat_q(stat_q), .cnt_q(cnt_q),
  .addr_q(addr_q), .host_word(host_word), .end_flag(end_flag),
  .ready_flag(ready_flag), .done(done), .irq(irq)
);

// File: tb/sim_host_xfer_engine.sv
module sim_host_xfer_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 0, cnt_we = 0, addr_we = 0, trig = 0, lvl_en = 0, host_rd = 0;
  logic [7:0]  ctl_data = 0;
  logic [15:0] cnt_data = 0, addr_data = 0;
  logic [2:0]  dest_mode = 0;
  logic [15:0] buf_rdata;
  logic [12:0] buf_raddr;
  logic [15:0] host_word, cnt_q, addr_q;
  logic [7:0]  ctl_q, stat_q;
  logic        end_flag, ready_flag, done, irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] e_cnt, e_addr;
  logic [7:0]  e_stat, e_ctl;
  logic        e_end, e_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] buf_byte(input logic [13:0] a);
    return 8'(a * 14'd37 + 14'd11) ^ 8'(a >> 6);
  endfunction

  assign buf_rdata = {buf_byte({buf_raddr, 1'b0}), buf_byte({buf_raddr, 1'b1})};

  host_xfer_engine u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " stat"}, stat_q, e_stat);
    chk({req, " cnt"}, cnt_q, e_cnt);
    chk({req, " addr"}, addr_q, e_addr);
    chk({req, " end"}, end_flag, e_end);
    chk({req, " ready"}, ready_flag, e_ready);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    ctl_we = 0; cnt_we = 0; addr_we = 0; trig = 0; host_rd = 0;
  endtask

  task automatic set_ctl(input logic [7:0] v);
    ctl_we = 1; ctl_data = v; tick;
    e_ctl = v;
    if (!v[1]) begin e_stat[3] = 1; e_stat[1] = 1; end
  endtask

  task automatic load(input logic [15:0] c, input logic [15:0] a);
    cnt_we = 1; cnt_data = c; addr_we = 1; addr_data = a; tick;
    e_cnt = c; e_addr = a;
  endtask

  task automatic start(input logic [2:0] m);
    trig = 1; dest_mode = m; tick;
    if (e_ctl[1]) begin
      e_stat[3] = 0; e_cnt[15:12] = 4'h0; e_end = 0; e_ready = 0;
      if (m == 3'd2 || m == 3'd3) begin e_stat[1] = 0; e_ready = 1; end
    end
  endtask

  // one host read, checked against the bench model
  task automatic read_word(input string req);
    logic [15:0] w;
    logic [13:0] a;
    logic        fin;
    logic [15:0] n;
    a = {e_addr[13:1], 1'b0};
    fin = 0;
    if (!e_stat[1]) begin
      w = {buf_byte(a), buf_byte(a + 14'd1)};
      n = e_cnt - 16'd2;
      e_addr = e_addr + 16'd2;
      e_cnt = n;
      if ($signed(n) <= 0) begin
        fin = 1; e_cnt = 16'hF000; e_stat[3] = 1; e_stat[1] = 1; e_stat[6] = 0;
        e_ready = 0; e_end = 1;
      end
    end else w = 16'hFFFF;
    host_rd = 1; tick;
    chk({req, " word"}, host_word, w);
    chk({req, " done"}, done, fin);
    chk("R6 irq", irq, fin && e_ctl[6] && lvl_en);
  endtask

  // returns number of words read before the end pulse
  task automatic run_xfer(input logic [15:0] c, input logic [15:0] a, input logic [2:0] m,
                          input string req, output int words);
    load(c, a);
    start(m);
    chk_state("R3 after start");
    words = 0;
    while (!e_stat[1] && words < 5000) begin
      read_word(req);
      words++;
    end
    chk_state("R5 after end");
  endtask

  initial begin
    int nw;
    int seed;
    seed = 32'h1a2b;
    void'($urandom(seed));
    e_stat = 8'hFF; e_cnt = 0; e_addr = 0; e_end = 0; e_ready = 0; e_ctl = 0;
    #(CLK_PERIOD*2 + 1);
    @(negedge clk);
    chk_state("R1 reset");
    chk("R1 host_word", host_word, 16'hFFFF);
    chk("R1 done/irq", {done, irq}, 2'b00);
    rst_n = 1;
    tick;

    // R2: trigger ignored while output disabled
    load(16'h0010, 16'h0100);
    start(3'd2);
    chk_state("R2 disabled trigger ignored");
    read_word("R7 idle read");
    chk_state("R7 no change");

    // R5 boundary: count 1 closes after one word, irq enabled
    set_ctl(8'h42); lvl_en = 1;
    run_xfer(16'h0001, 16'h0200, 3'd2, "R4 count1", nw);
    chk("R5 count1 words", nw, 1);
    // high counter bits cleared at start (R2)
    run_xfer(16'hF004, 16'h0101, 3'd3, "R4 odd addr", nw);
    chk("R2 top bits cleared words", nw, 2);
    read_word("R7 after end");
    // wrap (R4)
    run_xfer(16'h0006, 16'h3FFE, 3'd2, "R4 wrap", nw);
    chk("R4 wrap addr", addr_q, 16'h4004);
    // irq gated by level enable (R6)
    lvl_en = 0;
    run_xfer(16'h0002, 16'h0010, 3'd2, "R6 lvl off", nw);
    lvl_en = 1; set_ctl(8'h02);
    run_xfer(16'h0003, 16'h0020, 3'd3, "R6 ien off", nw);
    chk("R5 count3 words", nw, 2);

    // R3: non-host destination keeps data unavailable
    load(16'h0008, 16'h0040);
    start(3'd4);
    chk_state("R3 non-host start");
    read_word("R7 non-host read");
    chk_state("R7 non-host no change");

    // R8: abort mid transfer
    set_ctl(8'h02);
    load(16'h0010, 16'h0080);
    start(3'd2);
    read_word("R4 pre-abort");
    set_ctl(8'h00);
    chk_state("R8 abort flags");
    read_word("R8 read after abort");
    chk_state("R8 no change");

    // random transfers
    for (int i = 0; i < 40; i++) begin
      logic [7:0] cv;
      cv = ($urandom % 2) ? 8'h42 : 8'h02;
      set_ctl(cv);
      lvl_en = 1'($urandom);
      run_xfer(16'($urandom % 64) | (16'($urandom % 2) << 13),
               16'($urandom), ($urandom % 2) ? 3'd2 : 3'd3, "R4 random", nw);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule